// File: doc/BRIEF.md
# Differential Buzzer Tone Generator

This block drives a piezo buzzer with a pair of opposite-phase square waves. Both waves come from a 32 kHz reference tick that arrives as a one-cycle pulse on the system clock. Two tone pitches are available: a fast one at one eighth of the tick rate (4 kHz) and a slow one at one sixteenth of it (2 kHz). Each has a 50% duty cycle.

A command decoder elsewhere in the chip delivers 8-bit codes on a valid-qualified port. The block keeps its own tone enable and pitch selection, so a single code changes them and the setting holds until another code arrives. A system-enable level from the clock-control logic gates the whole output.

Whenever the tone is off or the system is disabled, both buzzer lines sit low. Turning the tone back on restarts the divider, so the first half period has its full length. A change of pitch while the tone is sounding waits for the end of the current half period.

Top module: `buzzer_tone_gen`

## Requirements
- R1: After reset, `bz_p` and `bz_n` are low, the tone is off and the slow pitch (16 ticks per period) is selected.
- R2: A code accepted with `cmd_valid` high whose top three bits are 010 selects the fast pitch, whatever the low five bits are. One whose top three bits are 011 selects the slow pitch. In steady state `bz_p` stays high for 4 ticks (fast) or 8 ticks (slow).
- R3: An accepted code 0x09 turns the tone on and an accepted code 0x08 turns it off. The outputs follow on the second clock edge after the edge that accepts the code.
- R4: While the tone sounds, `bz_n` is always the inverse of `bz_p`.
- R5: While `sys_en` is low, both outputs are low from the first clock edge after `sys_en` falls.
- R6: Each half period spans exactly the selected number of ticks (4 or 8), giving a 50% duty cycle.
- R7: A pitch change made while sounding takes effect only at the next half-period boundary. No half period is ever shortened.
- R8: On every start, whether from a tone-on code or from `sys_en` rising, the divider restarts: `bz_p` goes high first and its first high phase spans a full half period of ticks.
- R9: Codes other than 0x08, 0x09, 010xxxxx and 011xxxxx are ignored, and so is any code presented while `cmd_valid` is low. The tone state and pitch stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse at the 32 kHz reference rate |
| sys_en | input | 1 | System enable level; low forces both outputs low |
| cmd_valid | input | 1 | Qualifies `cmd_code` for one cycle |
| cmd_code | input | 8 | Decoded 8-bit command code |
| bz_p | output | 1 | Buzzer drive, true phase |
| bz_n | output | 1 | Buzzer drive, inverted phase |

## Verification
The timing of each result is fixed by the registers on its path. A tone-on or tone-off code shows at the outputs two edges after the accepting edge: one edge for the enable register and one for the divider. A falling `sys_en` shows after one edge. A toggle of the outputs appears on the edge that consumes the last tick of a half period. The bench runs a behavioural model that advances on the same edges from the same inputs and compares both outputs on every falling clock edge, away from the active edge. Directed checks are placed at exactly those edge counts after each command, and half-period lengths are measured in clocks once the divider is in steady state.

// File: rtl/tone_pkg.sv
// Shared definitions for the buzzer tone generator.
// Assumes 8-bit command codes already framed by an upstream decoder.
package tone_pkg;

    localparam int unsigned CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_TONE_ON  = 8'h09;
    localparam logic [CODE_W-1:0] CODE_TONE_OFF = 8'h08;
    localparam logic [2:0]        PFX_FAST      = 3'b010;
    localparam logic [2:0]        PFX_SLOW      = 3'b011;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ON,
        OP_OFF,
        OP_FAST,
        OP_SLOW
    } tone_op_e;

    // Maps a raw code onto the operation it requests; unknown codes give OP_NONE.
    function automatic tone_op_e classify(input logic [CODE_W-1:0] code);
        tone_op_e op;
        op = OP_NONE;
        if (code == CODE_TONE_ON) begin
            op = OP_ON;
        end else if (code == CODE_TONE_OFF) begin
            op = OP_OFF;
        end else if (code[CODE_W-1 -: 3] == PFX_FAST) begin
            op = OP_FAST;
        end else if (code[CODE_W-1 -: 3] == PFX_SLOW) begin
            op = OP_SLOW;
        end
        return op;
    endfunction

endpackage

// File: rtl/tone_cmd_regs.sv
// Holds the tone enable and the pitch selection, updated by decoded codes.
// Assumes cmd_valid is high for exactly the cycles that carry a code.
module tone_cmd_regs
    import tone_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output logic              tone_en,
    output logic              sel_fast
);

    tone_op_e op;

    // Qualify the classified code with its valid strobe.
    always_comb begin
        op = cmd_valid ? classify(cmd_code) : OP_NONE;
    end

    // Apply the requested operation to the setting registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_en  <= 1'b0;
            sel_fast <= 1'b0;
        end else begin
            case (op)
                OP_ON:   tone_en  <= 1'b1;
                OP_OFF:  tone_en  <= 1'b0;
                OP_FAST: sel_fast <= 1'b1;
                OP_SLOW: sel_fast <= 1'b0;
                default: ;
            endcase
        end
    end

    p_fast_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code[CODE_W-1 -: 3] == PFX_FAST) |=> sel_fast);

    p_slow_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code[CODE_W-1 -: 3] == PFX_SLOW) |=> !sel_fast);

    p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(tone_en) && $stable(sel_fast)));

endmodule

// File: rtl/tone_divider.sv
// Divides the reference tick into a square-wave phase of selectable length.
// Assumes both dividers are even and at least 4; the pitch is latched only
// at half-period boundaries or while the divider is idle.
module tone_divider #(
    parameter int unsigned FAST_DIV = 8,
    parameter int unsigned SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic sel_fast,
    output logic live,
    output logic phase
);

    localparam int unsigned FAST_HALF = FAST_DIV / 2;
    localparam int unsigned SLOW_HALF = SLOW_DIV / 2;
    localparam int unsigned MAX_HALF  = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
    localparam int unsigned CNT_W     = (MAX_HALF > 2) ? $clog2(MAX_HALF) : 1;
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);

    logic [CNT_W-1:0] cnt;
    logic             act_fast;
    logic [CNT_W-1:0] last;

    // Final count of the half period currently in progress.
    always_comb begin
        last = act_fast ? FAST_LAST : SLOW_LAST;
    end

    // Idle/restart handling, tick counting and phase toggling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live     <= 1'b0;
            phase    <= 1'b0;
            cnt      <= '0;
            act_fast <= 1'b0;
        end else if (!run || !live) begin
            live     <= run;
            phase    <= 1'b0;
            cnt      <= '0;
            act_fast <= sel_fast;
        end else if (tick) begin
            if (cnt == last) begin
                cnt      <= '0;
                phase    <= ~phase;
                act_fast <= sel_fast;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (cnt <= last));

    p_phase_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(live) && (phase != $past(phase))) |-> $past(tick));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(live)) |-> (!phase && cnt == '0));

    p_pitch_at_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(live) && (act_fast != $past(act_fast))) |-> (phase != $past(phase)));

    initial begin
        a_even_div: assert ((FAST_DIV % 2 == 0) && (SLOW_DIV % 2 == 0) && FAST_DIV >= 4 && SLOW_DIV >= 4);
    end

endmodule

// File: rtl/buzzer_tone_gen.sv
// Top level of the buzzer tone generator: setting registers, divider and
// a complementary output pair. Assumes tick is a single-cycle pulse and
// sys_en is synchronous to clk.
module buzzer_tone_gen
    import tone_pkg::*;
#(
    parameter int unsigned FAST_DIV = 8,
    parameter int unsigned SLOW_DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sys_en,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    output logic       bz_p,
    output logic       bz_n
);

    logic tone_en;
    logic sel_fast;
    logic run;
    logic live;
    logic phase;

    tone_cmd_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .tone_en   (tone_en),
        .sel_fast  (sel_fast)
    );

    // The divider runs only while the tone is on and the system is enabled.
    always_comb begin
        run = tone_en & sys_en;
    end

    tone_divider #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .sel_fast (sel_fast),
        .live     (live),
        .phase    (phase)
    );

    // Drive the opposite-phase pair, both low while idle.
    always_comb begin
        bz_p = live & ~phase;
        bz_n = live &  phase;
    end

    p_complement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bz_p || bz_n) |-> (bz_p != bz_n));

    p_sys_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en |=> (!bz_p && !bz_n));

    p_tone_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_TONE_OFF) |=> ##1 (!bz_p && !bz_n));

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (!bz_p && !bz_n));

endmodule

// File: tb/test_buzzer_tone_gen.sv
// Self-checking bench: a behavioural model advances on each rising edge and
// both outputs are compared with it on every falling edge.
module test_buzzer_tone_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       sys_en = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       bz_p;
    logic       bz_n;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    buzzer_tone_gen i_buzzer_tone_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sys_en    (sys_en),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .bz_p      (bz_p),
        .bz_n      (bz_n)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference tick every fourth clock.
    int tdiv = 0;
    always @(negedge clk) begin
        if (tdiv == 3) begin
            tdiv <= 0;
            tick <= 1'b1;
        end else begin
            tdiv <= tdiv + 1;
            tick <= 1'b0;
        end
    end

    // Behavioural model of the requirements.
    bit m_on, m_fast, m_live, m_ph, m_act_fast;
    int m_ticks;
    always @(posedge clk) begin
        bit run;
        if (!rst_n) begin
            m_on = 0; m_fast = 0; m_live = 0; m_ph = 0; m_ticks = 0; m_act_fast = 0;
        end else begin
            run = m_on && sys_en;
            if (!run || !m_live) begin
                m_live = run; m_ph = 0; m_ticks = 0; m_act_fast = m_fast;
            end else if (tick) begin
                m_ticks++;
                if (m_ticks == (m_act_fast ? 4 : 8)) begin
                    m_ticks = 0; m_ph = !m_ph; m_act_fast = m_fast;
                end
            end
            if (cmd_valid) begin
                if (cmd_code == 8'h09) m_on = 1;
                else if (cmd_code == 8'h08) m_on = 0;
                else if (cmd_code[7:5] == 3'b010) m_fast = 1;
                else if (cmd_code[7:5] == 3'b011) m_fast = 0;
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, {30'd0, bz_p, bz_n}, {30'd0, m_live && !m_ph, m_live && m_ph});
        end
    end

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 8'h00;
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (bz_p) @(negedge clk);
        while (!bz_p) @(negedge clk);
        while (bz_p) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        check("R1", {31'd0, bz_p | bz_n}, 0);
        rst_n  = 1'b1;
        sys_en = 1'b1;
        @(negedge clk);
        check("R1", {30'd0, bz_p, bz_n}, 0);
        repeat (20) @(negedge clk);
        check("R1", {30'd0, bz_p, bz_n}, 0);

        // Tone on: visible on the second edge after acceptance.
        cur_req = "R3";
        send(8'h09);
        check("R3", {31'd0, bz_p}, 0);
        @(negedge clk);
        check("R8", {30'd0, bz_p, bz_n}, 2);

        cur_req = "R6";
        measure_high(n);
        check("R6", n, 32);

        cur_req = "R2";
        send(8'h5F);
        repeat (40) @(negedge clk);
        measure_high(n);
        check("R2", n, 16);

        cur_req = "R7";
        repeat (5) @(negedge clk);
        send(8'h60);
        repeat (3) @(negedge clk);
        send(8'h40);
        repeat (9) @(negedge clk);
        send(8'h7B);
        repeat (80) @(negedge clk);
        measure_high(n);
        check("R7", n, 32);

        cur_req = "R9";
        send(8'h01);
        send(8'h80);
        send(8'hA7);
        send(8'h0C);
        @(negedge clk);
        cmd_code = 8'h08;
        repeat (6) @(negedge clk);
        cmd_code = 8'h40;
        repeat (6) @(negedge clk);
        cmd_code = 8'h00;
        measure_high(n);
        check("R9", n, 32);

        cur_req = "R5";
        repeat (7) @(negedge clk);
        sys_en = 1'b0;
        @(negedge clk);
        check("R5", {30'd0, bz_p, bz_n}, 0);
        repeat (30) @(negedge clk);
        check("R5", {30'd0, bz_p, bz_n}, 0);

        cur_req = "R8";
        sys_en = 1'b1;
        @(negedge clk);
        check("R8", {30'd0, bz_p, bz_n}, 2);
        measure_high(n);
        check("R8", n, 32);

        cur_req = "R4";
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            check("R4", {31'd0, bz_p ^ bz_n}, 1);
        end

        cur_req = "R3";
        send(8'h08);
        @(negedge clk);
        check("R3", {30'd0, bz_p, bz_n}, 0);
        repeat (40) @(negedge clk);
        check("R3", {30'd0, bz_p, bz_n}, 0);

        finish_run();
    end

endmodule